// File: doc/BRIEF.md
# SDRAM Auto Refresh Sequencer

This block sits on the controller side of a synchronous DRAM interface and keeps the array refreshed. A free-running interval timer marks each point at which one more refresh becomes owed. A small saturating counter keeps track of owed refreshes. While any refresh is owed, the sequencer asks the bus arbiter for the command pins. Once the arbiter grants them, the sequencer owns the bus until the refresh cycle time has run out.

On a grant, the sequencer samples the per-bank open flags. If any row is open, it first closes every bank with a precharge-all command. It then waits the precharge time and issues the auto refresh command. If all banks are already closed, the refresh command comes straight away. No bank or row address goes out with the refresh. A model of the device's internal row/bank refresh counter advances on each refresh instead, and raises a one-cycle pulse when it wraps, so coverage can be checked.

The state machine has six states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing owed |
| `ST_ASK` | Request raised, waiting for grant |
| `ST_PRECHARGE` | Precharge-all command on the bus |
| `ST_WAIT_RP` | Precharge wait |
| `ST_REFRESH` | Auto refresh command on the bus |
| `ST_WAIT_RFC` | Refresh cycle wait |

Its transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_ASK` | A refresh is owed |
| `ST_ASK` | `ST_PRECHARGE` | Grant arrives and any bank is open |
| `ST_ASK` | `ST_REFRESH` | Grant arrives and all banks are closed |
| `ST_PRECHARGE` | `ST_WAIT_RP` | Always |
| `ST_WAIT_RP` | `ST_REFRESH` | Wait timer expired |
| `ST_REFRESH` | `ST_WAIT_RFC` | Always |
| `ST_WAIT_RFC` | `ST_IDLE` | Wait timer expired |

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset, `req`, `busy`, `urgent` and `wrap` are 0. The command pins show NOP (`ras_n`, `cas_n`, `we_n` all 1, `a10` 0), `cke` is 1, and `ref_row` and `ref_bank` are 0.
- R2: One refresh becomes owed at every INTERVAL-th rising edge after reset. The first is owed at edge INTERVAL. With nothing owed before it, `req` goes high at edge INTERVAL+1.
- R3: `req` stays high until `grant` is sampled high. If no `bank_open` bit is set at that edge, the next cycle carries the refresh command (`ras_n`=0, `cas_n`=0, `we_n`=1), with no precharge.
- R4: If any `bank_open` bit is set when `grant` is sampled, the next cycle carries precharge-all (`ras_n`=0, `cas_n`=1, `we_n`=0, `a10`=1). The refresh command follows exactly T_RP cycles after the precharge-all cycle.
- R5: Every cycle between the two commands, and the T_RFC-1 cycles after the refresh command, are NOP. No precharge follows a refresh. `busy` is high from the cycle after the grant through the last wait cycle, and is low with NOP on the pins otherwise. `req` and `busy` are never high together.
- R6: At most MAX_DEBT refreshes are owed; an interval expiring while the count is full is dropped. `urgent` is high exactly while MAX_DEBT refreshes are owed.
- R7: When an interval expires in the same cycle as a refresh command, the owed count is unchanged.
- R8: Each refresh command advances the modelled counter, visible the cycle after. The bank advances first. When the bank wraps from BANKS-1 to 0, the row advances modulo ROWS.
- R9: `wrap` pulses for one cycle, the cycle after the refresh taken at row ROWS-1 and bank BANKS-1. In that cycle `ref_row` and `ref_bank` read 0.
- R10: `a10` is high only during a precharge-all cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open | input | BANKS | One flag per bank, 1 when a row is open |
| grant | input | 1 | Arbiter grants the command bus |
| req | output | 1 | Request for the command bus |
| urgent | output | 1 | Owed count is full; all other traffic should be held off |
| busy | output | 1 | Sequencer owns the command bus |
| cke | output | 1 | Clock enable, held high |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | All-banks select for precharge |
| ref_row | output | RW | Modelled internal refresh row |
| ref_bank | output | BW | Modelled internal refresh bank |
| wrap | output | 1 | Refresh counter wrapped |

## Verification
Two functions can fall in the same cycle: the interval timer adding an owed refresh, and a refresh command consuming one. When they coincide, the count must stay where it was.

The bench provokes this with a sweep. It withholds the grant for one interval plus a delay that steps across a whole interval, and alternates closed and open banks so the refresh command lands at every offset from the interval boundary. A behavioural reference model judges each cycle's pins, `req` and `urgent`. It also records that at least one coincidence occurred, so a wrong owed count would surface as an extra or missing request later on.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RFC
    } rfs_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam sd_cmd_t CMD_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam sd_cmd_t CMD_AREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
    parameter int unsigned INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/rfs_debt.sv
module rfs_debt #(
    parameter int unsigned MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic consume,
    output logic owed,
    output logic full
);
    localparam int unsigned DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] TOP = DW'(MAX_DEBT);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick && !consume && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end else if (consume && !tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign owed = (cnt != '0);
    assign full = (cnt == TOP);
endmodule

// File: rtl/rfs_wait_timer.sv
module rfs_wait_timer #(
    parameter int unsigned WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] load_val,
    output logic          expired
);
    logic [WW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rfs_walker.sv
module rfs_walker #(
    parameter int unsigned ROWS  = 4096,
    parameter int unsigned BANKS = 4,
    parameter int unsigned RW    = 12,
    parameter int unsigned BW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [RW-1:0] row,
    output logic [BW-1:0] bank,
    output logic          wrap
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    logic bank_last;

    generate
        if (BANKS > 1) begin : g_banks
            localparam logic [BW-1:0] LAST_BANK = BW'(BANKS - 1);
            logic [BW-1:0] bank_q;
            always_ff @(posedge clk) begin
                if (!rst_n)    bank_q <= '0;
                else if (step) bank_q <= (bank_q == LAST_BANK) ? '0 : bank_q + 1'b1;
            end
            assign bank      = bank_q;
            assign bank_last = (bank_q == LAST_BANK);
        end else begin : g_single
            assign bank      = '0;
            assign bank_last = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row  <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= step && bank_last && (row == LAST_ROW);
            if (step && bank_last) row <= (row == LAST_ROW) ? '0 : row + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import rfs_pkg::*;
#(
    parameter int unsigned INTERVAL = 1560,
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned T_RP     = 3,
    parameter int unsigned T_RFC    = 9,
    parameter int unsigned ROWS     = 4096,
    parameter int unsigned BANKS    = 4,
    localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BANKS-1:0] bank_open,
    input  logic             grant,
    output logic             req,
    output logic             urgent,
    output logic             busy,
    output logic             cke,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             a10,
    output logic [RW-1:0]    ref_row,
    output logic [BW-1:0]    ref_bank,
    output logic             wrap
);
    localparam int unsigned WMAX    = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int unsigned WW      = $clog2(WMAX + 1);
    localparam int unsigned RP_LOAD = (T_RP  >= 2) ? T_RP  - 2 : 0;
    localparam int unsigned RFC_LOAD = (T_RFC >= 2) ? T_RFC - 2 : 0;

    rfs_state_e    state, nxt;
    sd_cmd_t       cmd;
    logic          tick, owed, full, consume;
    logic          tm_load, tm_expired;
    logic [WW-1:0] tm_val;

    rfs_interval #(.INTERVAL(INTERVAL)) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rfs_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .consume(consume),
        .owed   (owed),
        .full   (full)
    );

    rfs_wait_timer #(.WW(WW)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tm_load),
        .load_val(tm_val),
        .expired (tm_expired)
    );

    rfs_walker #(.ROWS(ROWS), .BANKS(BANKS), .RW(RW), .BW(BW)) u_walker (
        .clk  (clk),
        .rst_n(rst_n),
        .step (consume),
        .row  (ref_row),
        .bank (ref_bank),
        .wrap (wrap)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (owed)       nxt = ST_ASK;
            ST_ASK:       if (grant)      nxt = (|bank_open) ? ST_PRECHARGE : ST_REFRESH;
            ST_PRECHARGE:                 nxt = ST_WAIT_RP;
            ST_WAIT_RP:   if (tm_expired) nxt = ST_REFRESH;
            ST_REFRESH:                   nxt = ST_WAIT_RFC;
            ST_WAIT_RFC:  if (tm_expired) nxt = ST_IDLE;
            default:                      nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd     = CMD_NOP;
        req     = 1'b0;
        busy    = 1'b0;
        consume = 1'b0;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_ASK: req = 1'b1;
            ST_PRECHARGE: begin
                cmd     = CMD_PALL;
                busy    = 1'b1;
                tm_load = 1'b1;
                tm_val  = WW'(RP_LOAD);
            end
            ST_WAIT_RP: busy = 1'b1;
            ST_REFRESH: begin
                cmd     = CMD_AREF;
                busy    = 1'b1;
                consume = 1'b1;
                tm_load = 1'b1;
                tm_val  = WW'(RFC_LOAD);
            end
            ST_WAIT_RFC: busy = 1'b1;
            default: ;
        endcase
    end

    assign urgent = full;
    assign cke    = 1'b1;
    assign ras_n  = cmd.ras_n;
    assign cas_n  = cmd.cas_n;
    assign we_n   = cmd.we_n;
    assign a10    = cmd.a10;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int unsigned BANKS = 4,
    parameter int unsigned RW    = 12,
    parameter int unsigned BW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          busy,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          a10,
    input logic [RW-1:0] row,
    input logic [BW-1:0] bank,
    input logic          wrap
);
    logic is_pall, is_aref, is_nop;
    assign is_pall = !ras_n &&  cas_n && !we_n;
    assign is_aref = !ras_n && !cas_n &&  we_n;
    assign is_nop  =  ras_n &&  cas_n &&  we_n;

    a_r5_req_busy_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && busy));

    a_r4_pall_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |=> (is_nop && busy));

    a_r5_aref_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        is_aref |=> is_nop);

    a_r5_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> is_nop);

    a_r10_a10_pall_only: assert property (@(posedge clk) disable iff (!rst_n)
        a10 |-> is_pall);

    a_r9_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (row == '0 && bank == '0));

    a_r8_bank_step: assert property (@(posedge clk) disable iff (!rst_n)
        is_aref |=> (($past(bank) == BW'(BANKS - 1)) ? (bank == '0)
                                                    : (bank == $past(bank) + 1'b1)));
endmodule

bind sdram_refresh_seq rfs_checker #(.BANKS(BANKS), .RW(RW), .BW(BW)) u_rfs_checker (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .busy (busy),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .a10  (a10),
    .row  (ref_row),
    .bank (ref_bank),
    .wrap (wrap)
);

// File: tb/sdram_refresh_seq_test.sv
`timescale 1ns/1ps
module sdram_refresh_seq_test;
    localparam int INTERVAL = 40;
    localparam int MAX_DEBT = 3;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 5;
    localparam int ROWS     = 4;
    localparam int BANKS    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_open = '0;
    logic       grant = 1'b0;
    logic       req, urgent, busy, cke, ras_n, cas_n, we_n, a10, wrap;
    logic [1:0] ref_row;
    logic [0:0] ref_bank;

    always #2.5 clk = ~clk;

    sdram_refresh_seq #(
        .INTERVAL(INTERVAL), .MAX_DEBT(MAX_DEBT), .T_RP(T_RP),
        .T_RFC(T_RFC), .ROWS(ROWS), .BANKS(BANKS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .grant(grant),
        .req(req), .urgent(urgent), .busy(busy), .cke(cke),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
        .ref_row(ref_row), .ref_bank(ref_bank), .wrap(wrap)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state: phase 0 idle, 1 asking, 2 precharge, 3 wait,
    // 4 refresh, 5 refresh wait
    int m_tcnt, m_debt, m_phase, m_mark, m_row, m_bank, m_coinc;
    bit m_wrap;
    int cyc;

    // Event tallies taken from the pins
    int n_aref, n_pall, n_wrap, pall_cyc, first_req, first_aref;
    bit pall_pending;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_tcnt = 0; m_debt = 0; m_phase = 0; m_mark = 0;
        m_row = 0; m_bank = 0; m_wrap = 0;
    endtask

    task automatic model_update();
        bit tick, dec;
        int np;
        tick = (m_tcnt == INTERVAL - 1);
        dec  = (m_phase == 4);
        if (tick && dec) m_coinc++;
        np = m_phase;
        case (m_phase)
            0: if (m_debt > 0) np = 1;
            1: if (grant) np = (bank_open != 0) ? 2 : 4;
            2: np = 3;
            3: if (cyc + 1 == m_mark + T_RP) np = 4;
            4: np = 5;
            5: if (cyc + 1 == m_mark + T_RFC) np = 0;
            default: np = 0;
        endcase
        if (np == 2 || np == 4) m_mark = cyc + 1;
        m_tcnt = tick ? 0 : m_tcnt + 1;
        if (tick && !dec && m_debt < MAX_DEBT) m_debt++;
        else if (dec && !tick && m_debt > 0) m_debt--;
        m_wrap = dec && (m_row == ROWS - 1) && (m_bank == BANKS - 1);
        if (dec) begin
            if (m_bank == BANKS - 1) begin
                m_bank = 0;
                m_row  = (m_row + 1) % ROWS;
            end else begin
                m_bank = m_bank + 1;
            end
        end
        m_phase = np;
    endtask

    task automatic compare();
        bit e_ras, e_cas, e_we;
        e_ras = !(m_phase == 2 || m_phase == 4);
        e_cas = !(m_phase == 4);
        e_we  = !(m_phase == 2);
        check(req == (m_phase == 1), "R3", "req", req, m_phase == 1);
        check(busy == (m_phase >= 2), "R5", "busy", busy, m_phase >= 2);
        check(ras_n == e_ras, "R4", "ras_n", ras_n, e_ras);
        check(cas_n == e_cas, "R3", "cas_n", cas_n, e_cas);
        check(we_n == e_we, "R4", "we_n", we_n, e_we);
        check(a10 == (m_phase == 2), "R10", "a10", a10, m_phase == 2);
        check(urgent == (m_debt == MAX_DEBT), "R6", "urgent", urgent, m_debt == MAX_DEBT);
        check(int'(ref_row) == m_row, "R8", "ref_row", ref_row, m_row);
        check(int'(ref_bank) == m_bank, "R8", "ref_bank", ref_bank, m_bank);
        check(wrap == m_wrap, "R9", "wrap", wrap, m_wrap);
        check(cke == 1'b1, "R1", "cke", cke, 1);
    endtask

    task automatic tally();
        if (req && first_req < 0) first_req = cyc;
        if (!ras_n && cas_n && !we_n) begin
            n_pall++;
            pall_cyc = cyc;
            pall_pending = 1;
        end
        if (!ras_n && !cas_n && we_n) begin
            n_aref++;
            if (first_aref < 0) first_aref = cyc;
            if (pall_pending)
                check(cyc - pall_cyc == T_RP, "R4", "precharge-to-refresh gap", cyc - pall_cyc, T_RP);
            pall_pending = 0;
        end
        if (wrap) n_wrap++;
    endtask

    task automatic step();
        @(posedge clk);
        cyc++;
        if (!rst_n) model_reset();
        else        model_update();
        @(negedge clk);
        if (rst_n) begin
            compare();
            tally();
        end
    endtask

    initial begin
        int base;
        cyc = 0; m_coinc = 0;
        n_aref = 0; n_pall = 0; n_wrap = 0; pall_cyc = 0;
        first_req = -1; first_aref = -1; pall_pending = 0;
        model_reset();
        repeat (3) step();
        rst_n = 1'b1;
        cyc = 0;
        // R1: reset state
        check(req == 0 && busy == 0 && urgent == 0 && wrap == 0, "R1", "flags after reset",
              {req, busy, urgent, wrap}, 0);
        check(ras_n && cas_n && we_n && !a10 && cke, "R1", "NOP after reset",
              {ras_n, cas_n, we_n, a10, cke}, 5'b11101);
        check(ref_row == 0 && ref_bank == 0, "R1", "counter after reset", ref_row, 0);

        // Phase A: banks closed, grant always given
        grant = 1'b1;
        repeat (200) step();
        check(first_req == INTERVAL + 1, "R2", "first request cycle", first_req, INTERVAL + 1);
        check(first_aref == INTERVAL + 2, "R3", "first refresh cycle", first_aref, INTERVAL + 2);
        check(n_pall == 0, "R3", "precharges with banks closed", n_pall, 0);
        check(n_aref == 4, "R2", "refreshes in 200 cycles", n_aref, 4);
        check(int'(ref_bank) == n_aref % BANKS && int'(ref_row) == (n_aref / BANKS) % ROWS,
              "R8", "counter position", {ref_row, ref_bank}, n_aref);

        // Phase B: a bank open, precharge-all first
        bank_open = 2'b01;
        base = n_aref;
        repeat (200) step();
        check(n_aref - base > 0 && n_pall == n_aref - base, "R4", "precharge per refresh",
              n_pall, n_aref - base);

        // Phase C: withhold grant, build and saturate the debt
        bank_open = 2'b00;
        grant = 1'b0;
        repeat (5 * INTERVAL) step();
        check(urgent == 1'b1, "R6", "urgent when full", urgent, 1);
        check(req == 1'b1, "R6", "request while held off", req, 1);
        base = n_aref;
        grant = 1'b1;
        repeat (21) step();
        check(n_aref - base == MAX_DEBT, "R6", "back-to-back drain", n_aref - base, MAX_DEBT);
        check(urgent == 1'b0, "R6", "urgent after drain", urgent, 0);
        repeat (14) step();
        check(n_aref - base <= MAX_DEBT + 1, "R6", "saturated debt", n_aref - base, MAX_DEBT + 1);

        // Phase D: sweep grant timing across one interval (R7 coincidence)
        for (int d = 0; d < INTERVAL; d++) begin
            bank_open = d[0] ? 2'b10 : 2'b00;
            grant = 1'b0;
            repeat (INTERVAL + d) step();
            grant = 1'b1;
            repeat (30) step();
        end
        check(m_coinc > 0, "R7", "tick and refresh coincided", m_coinc, 1);
        check(n_wrap == n_aref / (ROWS * BANKS), "R9", "wrap pulses", n_wrap, n_aref / (ROWS * BANKS));
        check(int'(ref_bank) == n_aref % BANKS && int'(ref_row) == (n_aref / BANKS) % ROWS,
              "R8", "final counter position", {ref_row, ref_bank}, n_aref);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule